// File: doc/BRIEF.md
# Inverted Event Sample Filter

This block decides whether each profiling sample is kept or thrown away. Software loads a 64-bit exclusion mask through a small register port. Every sample arrives with a 64-bit event vector. If any event is set in the vector and its bit is also set in the mask, the sample is vetoed. Otherwise it is kept. A separate global enable input bypasses the whole filter, so that every sample is kept.

Some positions can never hold a mask bit and always read back as zero: bit 0, bits 47 to 32, and every position left clear in the `IMPL_MASK` parameter. The `FEATURE_EN` parameter removes the filter altogether. In that build every register access raises a one-cycle illegal-access flag and no sample is ever dropped. The verdict, read data and illegal flag are all registered. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `sveto_filter`

## Requirements
- R1: After reset every mask bit is 0, `reg_rdata`, `reg_illegal`, `smp_record` and `smp_drop` are 0, and samples are kept.
- R2: One cycle after `smp_valid`, exactly one of `smp_record` and `smp_drop` is 1. `smp_drop` is 1 exactly when `filt_en` is 1 and the bitwise AND of `smp_events` and the mask is non-zero. With mask bits 3 and 5 set, a sample carrying event 3 or event 5 is dropped.
- R3: When `filt_en` is 0, no sample is dropped, whatever the mask holds.
- R4: Reserved bits 0 and 47..32 always read as 0. Writes to them are discarded, and event bits in those positions never cause a drop.
- R5: A position whose bit in `IMPL_MASK` is 0 reads as 0 and ignores writes, and its event bit never causes a drop.
- R6: A write (`reg_wr`=1) changes the mask at the clock edge. A sample presented in the same cycle as the write is judged with the old mask, and the next sample uses the new one.
- R7: One cycle after `reg_rd`=1, `reg_rdata` holds the mask as it was before any write in the same cycle. In every other cycle `reg_rdata` is 0.
- R8: With `FEATURE_EN`=0, `reg_illegal` is 1 for one cycle after each cycle in which `reg_wr` or `reg_rd` is 1, `reg_rdata` stays 0, and no sample is dropped. With `FEATURE_EN`=1, `reg_illegal` stays 0.
- R9: In a cycle after one without `smp_valid`, both `smp_record` and `smp_drop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the mask |
| reg_rd | input | 1 | Read strobe for the mask |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after `reg_rd` |
| reg_illegal | output | 1 | Access made while the feature is absent |
| filt_en | input | 1 | Global filter enable |
| smp_valid | input | 1 | Sample present |
| smp_events | input | 64 | Event vector of the sample |
| smp_record | output | 1 | Sample is kept |
| smp_drop | output | 1 | Sample is vetoed |

## Verification
A wrong bit in the mask register shows up at the ports in the cycle after the next read, as a wrong `reg_rdata`. It also shows up one cycle after the first sample that carries that event, as a flipped record or drop verdict. A flop that wrongly holds a reserved or unimplemented position is caught by the first read after an all-ones write. A mask update that lands a cycle early or late shows as a wrong verdict on the sample that shares a cycle with the write.

// File: rtl/sveto_pkg.sv
package sveto_pkg;
  localparam int unsigned EV_W = 64;
  // Positions that never hold a filter bit, whatever the implementation.
  localparam logic [EV_W-1:0] RSVD_MASK = 64'h0000_FFFF_0000_0001;

  typedef struct packed {
    logic record;
    logic drop;
  } verdict_t;
endpackage

// File: rtl/sveto_maskreg.sv
module sveto_maskreg
  import sveto_pkg::*;
#(
  parameter logic [EV_W-1:0] WRITABLE   = '0,
  parameter bit              FEATURE_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            rd,
  input  logic [EV_W-1:0] wdata,
  output logic [EV_W-1:0] mask,
  output logic [EV_W-1:0] rdata,
  output logic            illegal
);
  logic            access_ok;
  logic [EV_W-1:0] mask_q, mask_d;
  logic [EV_W-1:0] rdata_q, rdata_d;
  logic            illegal_q, illegal_d;
  logic            mask_ce;

  if (FEATURE_EN) begin : g_present
    assign access_ok = 1'b1;
  end else begin : g_absent
    assign access_ok = 1'b0;
  end

  always_comb begin
    mask_ce   = wr & access_ok;
    mask_d    = wdata & WRITABLE;
    rdata_d   = (rd & access_ok) ? mask_q : '0;
    illegal_d = (wr | rd) & ~access_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_ce) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q   <= '0;
      illegal_q <= 1'b0;
    end else begin
      rdata_q   <= rdata_d;
      illegal_q <= illegal_d;
    end
  end

  assign mask    = mask_q;
  assign rdata   = rdata_q;
  assign illegal = illegal_q;
endmodule

// File: rtl/sveto_judge.sv
module sveto_judge
  import sveto_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            valid,
  input  logic [EV_W-1:0] events,
  input  logic [EV_W-1:0] mask,
  output verdict_t        verdict
);
  logic     veto;
  verdict_t v_q, v_d;

  always_comb begin
    veto      = en & (|(events & mask));
    v_d.drop   = valid & veto;
    v_d.record = valid & ~veto;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else begin
      v_q <= v_d;
    end
  end

  assign verdict = v_q;
endmodule

// File: rtl/sveto_filter.sv
module sveto_filter
  import sveto_pkg::*;
#(
  parameter logic [63:0] IMPL_MASK  = 64'hFFFF_FFFF_FFFF_0FFF,
  parameter bit          FEATURE_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        reg_illegal,
  input  logic        filt_en,
  input  logic        smp_valid,
  input  logic [63:0] smp_events,
  output logic        smp_record,
  output logic        smp_drop
);
  localparam logic [EV_W-1:0] WRITABLE = IMPL_MASK & ~RSVD_MASK;

  logic [1:0]      rst_sync_q;
  logic            rst_n_sync;
  logic [EV_W-1:0] mask;
  verdict_t        verdict;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_sync = rst_sync_q[1];

  sveto_maskreg #(
    .WRITABLE   (WRITABLE),
    .FEATURE_EN (FEATURE_EN)
  ) u_maskreg (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .wdata   (reg_wdata),
    .mask    (mask),
    .rdata   (reg_rdata),
    .illegal (reg_illegal)
  );

  sveto_judge u_judge (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .en      (filt_en),
    .valid   (smp_valid),
    .events  (smp_events),
    .mask    (mask),
    .verdict (verdict)
  );

  assign smp_record = verdict.record;
  assign smp_drop   = verdict.drop;
endmodule

// File: rtl/sveto_filter_chk.sv
module sveto_filter_chk
  import sveto_pkg::*;
#(
  parameter bit FEATURE_EN = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [63:0] reg_rdata,
  input logic        reg_illegal,
  input logic        filt_en,
  input logic        smp_valid,
  input logic        smp_record,
  input logic        smp_drop
);
  // R2
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_record && smp_drop));

  // R2
  verdict_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> (smp_record || smp_drop));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> (!smp_record && !smp_drop));

  // R3
  bypass_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_en |=> !smp_drop);

  // R4
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & RSVD_MASK) == '0);

  // R7
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> (reg_rdata == '0));

  // R8
  illegal_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |=> (reg_illegal == !FEATURE_EN));

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr || reg_rd) |=> !reg_illegal);
endmodule

bind sveto_filter sveto_filter_chk #(.FEATURE_EN(FEATURE_EN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_rdata   (reg_rdata),
  .reg_illegal (reg_illegal),
  .filt_en     (filt_en),
  .smp_valid   (smp_valid),
  .smp_record  (smp_record),
  .smp_drop    (smp_drop)
);

// File: tb/sveto_filter_bench.sv
`timescale 1ns/1ps
module sveto_filter_bench;
  localparam logic [63:0] IMPL = 64'hFFFF_FFFF_FFFF_0FFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, filt_en = 1'b0, smp_valid = 1'b0;
  logic [63:0] reg_wdata = '0, smp_events = '0;
  logic [63:0] rdata_a, rdata_b;
  logic        ill_a, ill_b, rec_a, rec_b, drop_a, drop_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] model_mask;
  logic        exp_rec, exp_drop, exp_ill;
  logic [63:0] exp_rdata;

  always #2.5 clk = ~clk;

  sveto_filter #(.IMPL_MASK(IMPL), .FEATURE_EN(1'b1)) u_sveto_filter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_a), .reg_illegal(ill_a),
    .filt_en(filt_en), .smp_valid(smp_valid), .smp_events(smp_events),
    .smp_record(rec_a), .smp_drop(drop_a));

  sveto_filter #(.IMPL_MASK(IMPL), .FEATURE_EN(1'b0)) u_sveto_filter_absent (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .reg_illegal(ill_b),
    .filt_en(filt_en), .smp_valid(smp_valid), .smp_events(smp_events),
    .smp_record(rec_b), .smp_drop(drop_b));

  function automatic logic [63:0] writable_bits();
    logic [63:0] w;
    for (int i = 0; i < 64; i++)
      w[i] = IMPL[i] && !(i == 0 || (i >= 32 && i <= 47));
    return w;
  endfunction

  function automatic logic vetoed(logic en, logic [63:0] ev, logic [63:0] m);
    return en && ((ev & m) != 64'd0);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Checks the outputs due from the previous step, then drives new inputs
  // and works out what they should produce one edge later.
  task automatic step(logic wr, logic rd, logic [63:0] wd, logic en,
                      logic v, logic [63:0] ev);
    @(negedge clk);
    check("R2 record", {63'd0, rec_a}, {63'd0, exp_rec});
    check("R2 drop", {63'd0, drop_a}, {63'd0, exp_drop});
    check("R7 rdata", rdata_a, exp_rdata);
    check("R8 illegal present", {63'd0, ill_a}, 64'd0);
    check("R8 illegal absent", {63'd0, ill_b}, {63'd0, exp_ill});
    check("R8 rdata absent", rdata_b, 64'd0);
    check("R8 drop absent", {63'd0, drop_b}, 64'd0);
    check("R8 record absent", {63'd0, rec_b}, {63'd0, exp_rec | exp_drop});
    reg_wr = wr; reg_rd = rd; reg_wdata = wd;
    filt_en = en; smp_valid = v; smp_events = ev;
    exp_drop  = v && vetoed(en, ev, model_mask);
    exp_rec   = v && !exp_drop;
    exp_rdata = rd ? model_mask : 64'd0;
    exp_ill   = wr || rd;
    if (wr) model_mask = wd & writable_bits();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_mask = '0;
    exp_rec = 0; exp_drop = 0; exp_ill = 0; exp_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    check("R1 rdata", rdata_a, 64'd0);
    check("R1 verdict", {62'd0, rec_a, drop_a}, 64'd0);
    step(0, 1, 0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF);  // R1: reads 0, sample kept
    // R2: events 3 and 5 selected; R6: same-cycle sample uses old (zero) mask
    step(1, 0, 64'h28, 1, 1, 64'h8);
    step(0, 0, 0, 1, 1, 64'h8);
    step(0, 0, 0, 1, 1, 64'h20);
    step(0, 0, 0, 1, 1, 64'h10);
    step(0, 1, 0, 1, 1, 64'h28);
    // R3: enable off, overlapping events still kept
    step(0, 0, 0, 0, 1, 64'h28);
    // R9: no sample, no verdict
    step(0, 0, 0, 1, 0, 64'h28);
    // R4, R5: all-ones write, reserved and unimplemented read as zero
    step(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0);
    step(0, 1, 0, 1, 1, 64'h0000_FFFF_0000_F001);  // R4, R5: kept
    step(0, 0, 0, 1, 1, 64'h0000_0000_0001_0000);  // bit 16 dropped
    // R6: write clears mask, same-cycle sample still judged by full mask
    step(1, 1, 64'h0, 1, 1, 64'h2);
    step(0, 0, 0, 1, 1, 64'h2);
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] ev;
      logic [63:0] wd;
      ev = ($urandom_range(0, 1) == 1) ? (64'd1 << $urandom_range(0, 63))
                                       : {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      wd = {$urandom, $urandom} & {$urandom, $urandom};
      step($urandom_range(0, 7) == 0, $urandom_range(0, 3) == 0, wd,
           $urandom_range(0, 4) != 0, $urandom_range(0, 3) != 0, ev);
    end
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule